// File: doc/BRIEF.md
# Clock Throttle Duty Gate

This block produces a per-cycle run enable for a processor clock. A software-visible control word holds a throttle-on bit and a three-bit duty code. When throttling is on and the code is nonzero, the enable is high for `code` slots out of every eight-slot window. The window is timed by a free-running slot counter. Otherwise the enable stays high on every cycle. The clock gating cell and the bus decode sit outside the block. Writes arrive as a strobe with a data word, and the stored word is always visible on a read port.

Turning throttling on can also raise a system-management interrupt event. A write that takes the throttle-on bit from 0 to 1, while the external interrupt-enable input is high, gives a one-cycle event pulse. The same write sets two sticky flags: a summary flag shared with other interrupt causes, and a flag specific to the throttle cause. Each flag is cleared through its own write-one-to-clear strobe.

Top module: `clk_throttle_gate`

## Requirements
- R1: After reset the stored word reads 0x00000000, `run_en` is 1, `smi_pulse` is 0, and both status flags are 0.
- R2: A write stores only bit 4 (throttle on) and bits [2:0] (duty code) of `wr_data`. All other read bits are 0, and the stored word is unchanged in any cycle without `wr_en`.
- R3: While bit 4 is 0, or the duty code is 000 (reserved), `run_en` is 1 on every cycle.
- R4: While bit 4 is 1 and the code N is between 1 and 7, `run_en` is 1 exactly when the slot counter is below N. The counter runs 0..7 without stopping, so `run_en` is high in N of every 8 consecutive cycles.
- R5: A new control word affects `run_en` from the cycle after the write edge. A write does not reset the slot counter.
- R6: `smi_pulse` is 1 for exactly one cycle after a write edge that takes bit 4 from 0 to 1 while `smi_en_i` is 1. A write that leaves bit 4 at 1 raises no event, and neither does a write made while `smi_en_i` is 0.
- R7: The same event sets both `smi_top_sts` and `smi_thr_sts`. Each flag stays set until its own clear strobe is 1 at a clock edge. If an event and a clear reach the same edge, the flag is set.
- R8: Each clear strobe affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Stored control word |
| smi_en_i | input | 1 | Allows the throttle-on event |
| top_clr | input | 1 | Write-one-to-clear for the summary flag |
| thr_clr | input | 1 | Write-one-to-clear for the throttle flag |
| run_en | output | 1 | Per-cycle clock run enable |
| smi_pulse | output | 1 | One-cycle interrupt event |
| smi_top_sts | output | 1 | Sticky summary status |
| smi_thr_sts | output | 1 | Sticky throttle-cause status |

## Verification
The assertions check on every cycle that `run_en` is high whenever throttling is off or the code is 000, and that the slot counter steps by one modulo eight. They also check that an event pulse follows only an enabled write and lasts one cycle, that flags stay set until cleared, and that the stored word holds between writes. Other properties are shown only by the bench's scenarios, which compare against a cycle model on every clock: the exact N-of-8 pattern for each code, the masking of written data, and event suppression when the bit is already set. The bench scenarios also cover a set and a clear meeting at the same edge, and the independence of the two clears.

// File: rtl/ctg_pkg.sv
// Shared constants for the clock throttle duty gate.
// Assumes a one-word control register with one enable bit above a duty code field.
package ctg_pkg;
    localparam int DATA_W  = 32;
    localparam int CODE_W  = 3;
    localparam int EN_BIT  = 4;

    // Bits that hold state; every other bit reads as zero.
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << EN_BIT) | ((DATA_W'(1) << CODE_W) - DATA_W'(1));

    typedef struct packed {
        logic              thr_on;
        logic [CODE_W-1:0] code;
    } ctrl_t;
endpackage

// File: rtl/ctg_ctrl_reg.sv
// Control register: stores the throttle-on bit and the duty code, and flags a
// 0-to-1 write of the enable bit. Assumes wr_data is valid whenever wr_en is high.
module ctg_ctrl_reg
    import ctg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output logic              en_rise
);
    ctrl_t ctrl_q;

    // Capture the live fields on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.thr_on <= wr_data[EN_BIT];
            ctrl_q.code   <= wr_data[CODE_W-1:0];
        end
    end

    // Rebuild the read word with reserved bits forced to zero.
    always_comb begin
        rd_data = '0;
        rd_data[EN_BIT]       = ctrl_q.thr_on;
        rd_data[CODE_W-1:0]   = ctrl_q.code;
    end

    // A write that turns the enable bit on from off.
    always_comb en_rise = wr_en && wr_data[EN_BIT] && !ctrl_q.thr_on;

    assign ctrl = ctrl_q;

    // R2: the stored word holds between writes.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/ctg_duty_gen.sv
// Duty generator: a free-running slot counter and the compare that decides
// whether the current slot runs. Assumes a code of zero means no throttling.
module ctg_duty_gen
    import ctg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    output logic  run_en
);
    logic [CODE_W-1:0] slot_q;
    logic              bypass;

    // Step the slot counter every cycle; it wraps at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_q + 1'b1;
    end

    // Run in every slot when throttling is off or the code is reserved.
    always_comb bypass = !ctrl.thr_on || (ctrl.code == '0);

    // Run in the first N slots of the window.
    always_comb run_en = bypass || (slot_q < ctrl.code);

    // R3: off or code 000 always runs.
    p_full_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.thr_on || ctrl.code == '0) |-> run_en);

    // R4: the counter advances by one each cycle.
    p_slot_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_q == $past(slot_q) + 1'b1);
endmodule

// File: rtl/ctg_smi_status.sv
// Interrupt status: registers a one-cycle event pulse and two sticky flags.
// Assumes the event input is already gated by the external enable; a set wins
// over a clear at the same edge.
module ctg_smi_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic top_clr,
    input  logic thr_clr,
    output logic smi_pulse,
    output logic smi_top_sts,
    output logic smi_thr_sts
);
    // Register the event as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_pulse <= 1'b0;
        else        smi_pulse <= evt;
    end

    // Summary flag: set on event, cleared by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       smi_top_sts <= 1'b0;
        else if (evt)     smi_top_sts <= 1'b1;
        else if (top_clr) smi_top_sts <= 1'b0;
    end

    // Throttle-cause flag: set on event, cleared by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       smi_thr_sts <= 1'b0;
        else if (evt)     smi_thr_sts <= 1'b1;
        else if (thr_clr) smi_thr_sts <= 1'b0;
    end

    // R7: flags stay set until their own clear.
    p_top_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_top_sts && !top_clr) |=> smi_top_sts);
    p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_thr_sts && !thr_clr) |=> smi_thr_sts);
    // R7: an event always leaves both flags set.
    p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (smi_top_sts && smi_thr_sts));
endmodule

// File: rtl/clk_throttle_gate.sv
// Top level: control register, duty generator and interrupt status.
// Assumes a single clock domain; the run enable feeds an external gating cell.
module clk_throttle_gate
    import ctg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              smi_en_i,
    input  logic              top_clr,
    input  logic              thr_clr,
    output logic              run_en,
    output logic              smi_pulse,
    output logic              smi_top_sts,
    output logic              smi_thr_sts
);
    ctrl_t ctrl;
    logic  en_rise;
    logic  smi_evt;

    ctg_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ctrl(ctrl), .en_rise(en_rise)
    );

    ctg_duty_gen u_duty (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .run_en(run_en)
    );

    // Gate the enable-rise event with the external interrupt enable.
    always_comb smi_evt = en_rise && smi_en_i;

    ctg_smi_status u_sts (
        .clk(clk), .rst_n(rst_n), .evt(smi_evt),
        .top_clr(top_clr), .thr_clr(thr_clr),
        .smi_pulse(smi_pulse), .smi_top_sts(smi_top_sts), .smi_thr_sts(smi_thr_sts)
    );

    // R6: a pulse only follows an enabled write.
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |-> ($past(smi_en_i) && $past(wr_en)));
    // R6: the pulse lasts a single cycle.
    p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |=> !smi_pulse);
endmodule

// File: tb/tb_clk_throttle_gate.sv
module tb_clk_throttle_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        smi_en_i = 1'b0;
    logic        top_clr = 1'b0;
    logic        thr_clr = 1'b0;
    logic [31:0] rd_data;
    logic        run_en, smi_pulse, smi_top_sts, smi_thr_sts;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Behavioural model state.
    int m_en = 0, m_code = 0, m_slot = 0;
    int m_pulse = 0, m_top = 0, m_thr = 0;
    int ones_seen = 0;

    always #5 clk = ~clk;

    clk_throttle_gate dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .smi_en_i(smi_en_i), .top_clr(top_clr),
        .thr_clr(thr_clr), .run_en(run_en), .smi_pulse(smi_pulse),
        .smi_top_sts(smi_top_sts), .smi_thr_sts(smi_thr_sts)
    );

    // Model update at each edge from the inputs the bench is driving.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_en <= 0; m_code <= 0; m_slot <= 0;
            m_pulse <= 0; m_top <= 0; m_thr <= 0;
        end else begin
            automatic bit evt = wr_en && wr_data[4] && (m_en == 0) && smi_en_i;
            m_slot <= (m_slot + 1) % 8;
            if (wr_en) begin
                m_en   <= wr_data[4];
                m_code <= wr_data[2:0];
            end
            m_pulse <= evt;
            m_top <= evt ? 1 : (top_clr ? 0 : m_top);
            m_thr <= evt ? 1 : (thr_clr ? 0 : m_thr);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic compare();
        int exp_word = (m_en << 4) | m_code;
        int exp_run  = (m_en == 0 || m_code == 0) ? 1 : (m_slot < m_code ? 1 : 0);
        chk("R2", "rd_data", rd_data, exp_word);
        chk((m_en == 0 || m_code == 0) ? "R3" : "R4", "run_en", run_en, exp_run);
        chk("R6", "smi_pulse", smi_pulse, m_pulse);
        chk("R7", "smi_top_sts", smi_top_sts, m_top);
        chk("R8", "smi_thr_sts", smi_thr_sts, m_thr);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
        if (run_en) ones_seen++;
        wr_en = 1'b0; top_clr = 1'b0; thr_clr = 1'b0;
    endtask

    task automatic write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        // R1: reset values.
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "run_en", run_en, 1);
        chk("R1", "sts", {smi_pulse, smi_top_sts, smi_thr_sts}, 0);
        tick();

        // R2 masking and R6 event with smi enabled.
        smi_en_i = 1'b1;
        write(32'hFFFF_FFFF);
        chk("R2", "masked word", rd_data, 32'h17);
        chk("R6", "pulse after rise", smi_pulse, 1);
        tick();
        chk("R6", "pulse one cycle", smi_pulse, 0);
        chk("R7", "both flags", {smi_top_sts, smi_thr_sts}, 2'b11);

        // R8: clear only the summary flag.
        top_clr = 1'b1; tick();
        chk("R8", "top cleared thr kept", {smi_top_sts, smi_thr_sts}, 2'b01);
        thr_clr = 1'b1; tick();
        chk("R8", "thr cleared", smi_thr_sts, 0);

        // R6: write with bit already set raises nothing.
        write(32'h0000_0013);
        chk("R6", "no pulse when held", smi_pulse, 0);

        // R4/R5: each duty code, count ones over 16 cycles.
        for (int c = 0; c < 8; c++) begin
            write(32'h10 | c);
            ones_seen = 0;
            for (int k = 0; k < 16; k++) tick();
            chk(c == 0 ? "R3" : "R4", "ones per 16", ones_seen, c == 0 ? 16 : 2 * c);
        end

        // R3: disabled with nonzero code runs every cycle.
        write(32'h0000_0003);
        ones_seen = 0;
        for (int k = 0; k < 8; k++) tick();
        chk("R3", "off runs always", ones_seen, 8);

        // R6: rise with smi disabled raises nothing.
        smi_en_i = 1'b0;
        write(32'h0000_0015);
        chk("R6", "no pulse when gated", smi_pulse, 0);
        chk("R7", "flags untouched", {smi_top_sts, smi_thr_sts}, 0);

        // R7: set and clear at the same edge, set wins.
        write(32'h0);
        smi_en_i = 1'b1;
        top_clr = 1'b1; thr_clr = 1'b1;
        write(32'h0000_0012);
        chk("R7", "set beats clear", {smi_top_sts, smi_thr_sts}, 2'b11);

        // R5: mid-window code change takes effect next cycle.
        for (int k = 0; k < 11; k++) tick();
        write(32'h0000_0011);
        for (int k = 0; k < 12; k++) tick();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule